// File: doc/BRIEF.md
# Banked Interrupt Aggregator

This block gathers interrupt request lines from peripherals into several banks of 32 sources each and drives one interrupt line per bank toward a processor. Every source has its own trigger configuration: it can be level sensitive or edge sensitive, and either high/rising or low/falling active. Each source input passes through a two-flop synchronizer before any detection logic sees it.

Software uses a small register bus to reach six 32-bit registers per bank. These registers give the pending status of each source, an enable mask, a write-one-to-set register for raising interrupts from software, a write-one-to-clear register, a polarity register and a trigger-mode register. A bank's output is high whenever any enabled source in that bank is pending. Software reads the masked status to find out which source to service. The block does not choose among pending sources.

Interrupt number k is source input `src_in[k]`, which is bit k mod 32 of bank k/32. Reads are combinational: `reg_rdata` is valid in the same cycle as `reg_addr` while `reg_sel` is high. Writes take effect at the clock edge where `reg_sel` and `reg_wr` are both high.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset all enable bits and pending bits are 0, every polarity bit reads 1, the trigger-mode register of each bank reads its slice of the EDGE_RST parameter (bank 0 bits 15:13 set by default), and every bank output is low.
- R2: Bank b occupies byte addresses b*0x18 to b*0x18+0x17. Its registers sit at these offsets: status 0x00, enable 0x04, set 0x08, clear 0x0C, polarity 0x10 and mode 0x14. Enable, polarity and mode read back the last value written to them. A read of any address outside a mapped register returns 0.
- R3: A source with polarity 1 and mode 0 (level high) shows status 1 exactly while its synchronized input is 1. The status bit and the bank output follow an input change after two clock edges.
- R4: A source with polarity 0 and mode 0 (level low) shows status 1 exactly while its synchronized input is 0.
- R5: A source with polarity 1 and mode 1 (rising edge) becomes pending on a synchronized 0-to-1 transition. The status bit and the bank output rise after the third clock edge, and the bit stays pending after the input returns to 0.
- R6: A source with polarity 0 and mode 1 (falling edge) becomes pending on a synchronized 1-to-0 transition. A 0-to-1 transition does not make it pending.
- R7: Writing 1 to a bit of the clear register removes that source's pending state; writing 0 leaves it pending. A level source whose input is still active keeps status 1 after a clear. Pending state is never dropped in a cycle without a bus write.
- R8: Writing 1 to a bit of the set register makes that source pending at the write edge. The set and clear registers always read as 0.
- R9: Bank output b is the OR of (status AND enable) over bank b's 32 bits. A source whose enable bit is 0 does not drive the output.
- R10: Writes to the status register have no effect.
- R11: Banks are independent: a source in one bank changes only that bank's output and status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Bus access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| src_in | input | NUM_BANKS*32 | Raw interrupt source lines, index = interrupt number |
| irq_out | output | NUM_BANKS | One interrupt line per bank |

## Verification
The bench builds the block with its default parameters: five banks, an 8-bit address and bank 0 bits 15:13 reset to edge mode. With five banks the last bank sits at 0x60 and the first unmapped address is 0x78, so the bench can reach both the top of the map and the region just above it. The nonzero mode reset value lets the bench check that EDGE_RST is loaded per bank. The bench also measures the two-edge level latency and the three-edge edge latency to the exact cycle.

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl #(
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W = 8,
  parameter logic [NUM_BANKS*32-1:0] POL_RST = '1,
  parameter logic [NUM_BANKS*32-1:0] EDGE_RST = 'h0000_e000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_sel,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [NUM_BANKS*32-1:0] src_in,
  output logic [NUM_BANKS-1:0]    irq_out
);
  localparam int W = NUM_BANKS * 32;
  localparam int STRIDE = 24;
  localparam logic [ADDR_W-1:0] O_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] O_EN   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] O_SET  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] O_CLR  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] O_POL  = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] O_MODE = ADDR_W'(20);

  logic [W-1:0] en_q, pol_q, mode_q, pend_q, pend_d;
  logic [W-1:0] s1, s2, s3;
  logic [W-1:0] act, act_prev, status, set_m, clr_m;
  logic [NUM_BANKS-1:0] hit, st_en, st_pol, st_mode;
  logic [ADDR_W-1:0] off [NUM_BANKS];

  assign act      = ~(s2 ^ pol_q);
  assign act_prev = ~(s3 ^ pol_q);
  assign status   = pend_q | (~mode_q & act);
  assign pend_d   = (pend_q & ~clr_m) | set_m | (mode_q & act & ~act_prev);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(b * STRIDE);
    localparam logic [ADDR_W-1:0] TOP  = ADDR_W'(b * STRIDE + STRIDE);
    logic wr_b;
    assign hit[b]  = (reg_addr >= BASE) && (reg_addr < TOP);
    assign off[b]  = reg_addr - BASE;
    assign wr_b    = reg_sel & reg_wr & hit[b];
    assign st_en[b]   = wr_b && (off[b] == O_EN);
    assign st_pol[b]  = wr_b && (off[b] == O_POL);
    assign st_mode[b] = wr_b && (off[b] == O_MODE);
    assign set_m[b*32 +: 32] = (wr_b && off[b] == O_SET) ? reg_wdata : 32'h0;
    assign clr_m[b*32 +: 32] = (wr_b && off[b] == O_CLR) ? reg_wdata : 32'h0;
    assign irq_out[b] = |(status[b*32 +: 32] & en_q[b*32 +: 32]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= '0;
      s2     <= '0;
      s3     <= '0;
      en_q   <= '0;
      pol_q  <= POL_RST;
      mode_q <= EDGE_RST;
      pend_q <= '0;
    end else begin
      s1     <= src_in;
      s2     <= s1;
      s3     <= s2;
      pend_q <= pend_d;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (st_en[b])   en_q[b*32 +: 32]   <= reg_wdata;
        if (st_pol[b])  pol_q[b*32 +: 32]  <= reg_wdata;
        if (st_mode[b]) mode_q[b*32 +: 32] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = 32'h0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_sel && hit[b]) begin
        case (off[b])
          O_STAT:  reg_rdata = status[b*32 +: 32];
          O_EN:    reg_rdata = en_q[b*32 +: 32];
          O_POL:   reg_rdata = pol_q[b*32 +: 32];
          O_MODE:  reg_rdata = mode_q[b*32 +: 32];
          default: reg_rdata = 32'h0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk #(
  parameter int NUM_BANKS = 5,
  parameter int ADDR_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reg_sel,
  input logic                    reg_wr,
  input logic [ADDR_W-1:0]       reg_addr,
  input logic [31:0]             reg_rdata,
  input logic [NUM_BANKS-1:0]    irq_out,
  input logic [NUM_BANKS*32-1:0] en_q,
  input logic [NUM_BANKS*32-1:0] pend_q
);
  logic is_sc;
  always_comb begin
    is_sc = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (reg_addr == ADDR_W'(b * 24 + 8) || reg_addr == ADDR_W'(b * 24 + 12))
        is_sc = 1'b1;
  end

  a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && int'(reg_addr) >= NUM_BANKS * 24) |-> (reg_rdata == 32'h0));

  a_r8_set_clr_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && is_sc) |-> (reg_rdata == 32'h0));

  a_r7_drop_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_sel && reg_wr) |=> ((~pend_q & $past(pend_q)) == '0));

  a_r9_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (irq_out == '0));
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq_out(irq_out),
  .en_q(en_q), .pend_q(pend_q)
);

// File: tb/test_irq_bank_ctrl.sv
`timescale 1ns/1ps
module test_irq_bank_ctrl;
  localparam int NB = 5;
  localparam int AW = 8;
  localparam logic [AW-1:0] ST = 0, EN = 4, SET = 8, CLR = 12, POL = 16, MODE = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NB*32-1:0] src_in = '0;
  logic [NB-1:0] irq_out;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  irq_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) i_irq_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_in(src_in), .irq_out(irq_out));

  function automatic logic [AW-1:0] ra(int b, logic [AW-1:0] o);
    return AW'(b * 24) + o;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq_out", 32'(irq_out), 32'h0);
    rd(ra(0, EN), d);   check("R1 enable", d, 32'h0);
    rd(ra(0, ST), d);   check("R1 status", d, 32'h0);
    rd(ra(3, POL), d);  check("R1 polarity", d, 32'hffff_ffff);
    rd(ra(0, MODE), d); check("R1 mode bank0", d, 32'h0000_e000);
    rd(ra(1, MODE), d); check("R1 mode bank1", d, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(ra(4, POL), 32'h1234_5678);
    rd(ra(4, POL), d);  check("R2 polarity readback", d, 32'h1234_5678);
    wr(ra(4, POL), 32'hffff_ffff);
    wr(ra(2, MODE), 32'ha5a5_0000);
    rd(ra(2, MODE), d); check("R2 mode readback", d, 32'ha5a5_0000);
    wr(ra(2, MODE), 32'h0);
    wr(ra(3, EN), 32'h0f0f_0000);
    rd(ra(3, EN), d);   check("R2 enable readback", d, 32'h0f0f_0000);
    wr(ra(3, EN), 32'h0);
    rd(8'h78, d);       check("R2 unmapped 0x78", d, 32'h0);
    rd(8'h01, d);       check("R2 misaligned 0x01", d, 32'h0);
  endtask

  task automatic t_level_high;
    logic [31:0] d;
    wr(ra(1, EN), 32'h20);
    src_in[37] = 1'b1;
    idle(1); check("R3 irq before 2nd edge", 32'(irq_out[1]), 32'h0);
    idle(1); check("R3 irq after 2nd edge", 32'(irq_out[1]), 32'h1);
    rd(ra(1, ST), d); check("R3 status high", d, 32'h20);
    src_in[37] = 1'b0;
    idle(3);
    rd(ra(1, ST), d); check("R3 status follows low", d, 32'h0);
    check("R3 irq low", 32'(irq_out[1]), 32'h0);
    wr(ra(1, EN), 32'h0);
  endtask

  task automatic t_level_low;
    logic [31:0] d;
    wr(ra(1, POL), 32'hffff_ffbf);
    wr(ra(1, EN), 32'h40);
    idle(3);
    rd(ra(1, ST), d); check("R4 status active low", d, 32'h40);
    check("R4 irq", 32'(irq_out[1]), 32'h1);
    src_in[38] = 1'b1;
    idle(3);
    rd(ra(1, ST), d); check("R4 status inactive high", d, 32'h0);
    src_in[38] = 1'b0;
    idle(3);
    wr(ra(1, POL), 32'hffff_ffff);
    wr(ra(1, EN), 32'h0);
  endtask

  task automatic t_rising;
    logic [31:0] d;
    wr(ra(2, MODE), 32'h1);
    wr(ra(2, EN), 32'h1);
    src_in[64] = 1'b1;
    idle(2); check("R5 irq before 3rd edge", 32'(irq_out[2]), 32'h0);
    idle(1); check("R5 irq after 3rd edge", 32'(irq_out[2]), 32'h1);
    src_in[64] = 1'b0;
    idle(4);
    rd(ra(2, ST), d); check("R5 sticky after input low", d, 32'h1);
    wr(ra(2, CLR), 32'h1);
    rd(ra(2, ST), d); check("R7 clear edge pending", d, 32'h0);
    check("R7 irq after clear", 32'(irq_out[2]), 32'h0);
  endtask

  task automatic t_falling;
    logic [31:0] d;
    src_in[65] = 1'b1;
    wr(ra(2, POL), 32'hffff_fffd);
    wr(ra(2, MODE), 32'h3);
    wr(ra(2, EN), 32'h2);
    idle(4);
    rd(ra(2, ST), d); check("R6 rise does not latch", d, 32'h0);
    src_in[65] = 1'b0;
    idle(4);
    rd(ra(2, ST), d); check("R6 fall latches", d, 32'h2);
    check("R6 irq", 32'(irq_out[2]), 32'h1);
    wr(ra(2, CLR), 32'h0);
    rd(ra(2, ST), d); check("R7 zero clear no effect", d, 32'h2);
    wr(ra(2, CLR), 32'h2);
    rd(ra(2, ST), d); check("R7 clear falling pending", d, 32'h0);
    wr(ra(2, EN), 32'h0);
    wr(ra(2, MODE), 32'h0);
    wr(ra(2, POL), 32'hffff_ffff);
  endtask

  task automatic t_level_clear;
    logic [31:0] d;
    src_in[37] = 1'b1;
    idle(3);
    wr(ra(1, CLR), 32'h20);
    idle(2);
    rd(ra(1, ST), d); check("R7 level persists after clear", d, 32'h20);
    src_in[37] = 1'b0;
    idle(3);
    rd(ra(1, ST), d); check("R7 level gone", d, 32'h0);
  endtask

  task automatic t_set;
    logic [31:0] d;
    wr(ra(3, EN), 32'h8000_0000);
    wr(ra(3, SET), 32'h8000_0000);
    check("R8 irq after set", 32'(irq_out[3]), 32'h1);
    rd(ra(3, ST), d);  check("R8 status after set", d, 32'h8000_0000);
    rd(ra(3, SET), d); check("R8 set reads zero", d, 32'h0);
    rd(ra(3, CLR), d); check("R8 clear reads zero", d, 32'h0);
    wr(ra(3, CLR), 32'h8000_0000);
    check("R8 irq after clear", 32'(irq_out[3]), 32'h0);
    wr(ra(3, EN), 32'h0);
  endtask

  task automatic t_status_ro;
    logic [31:0] d;
    wr(ra(0, EN), 32'h1);
    wr(ra(0, ST), 32'hffff_ffff);
    rd(ra(0, ST), d); check("R10 status write ignored", d, 32'h0);
    check("R10 irq stays low", 32'(irq_out[0]), 32'h0);
    wr(ra(0, EN), 32'h0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    src_in[4*32+7] = 1'b1;
    idle(3);
    rd(ra(4, ST), d); check("R9 status while masked", d, 32'h80);
    check("R9 masked irq low", 32'(irq_out[4]), 32'h0);
    wr(ra(4, EN), 32'h80);
    check("R9 unmasked irq high", 32'(irq_out[4]), 32'h1);
    wr(ra(4, EN), 32'h7f);
    check("R9 other enables irq low", 32'(irq_out[4]), 32'h0);
    src_in[4*32+7] = 1'b0;
    wr(ra(4, EN), 32'h0);
    idle(3);
  endtask

  task automatic t_bank_iso;
    logic [31:0] d;
    wr(ra(0, EN), 32'h4);
    wr(ra(1, EN), 32'h4);
    src_in[2] = 1'b1;
    idle(3);
    check("R11 only bank0 irq", 32'(irq_out), 32'h1);
    rd(ra(1, ST), d); check("R11 bank1 status untouched", d, 32'h0);
    src_in[2] = 1'b0;
    idle(3);
    check("R11 all low", 32'(irq_out), 32'h0);
    wr(ra(0, EN), 32'h0);
    wr(ra(1, EN), 32'h0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_map();
    t_level_high();
    t_level_low();
    t_rising();
    t_falling();
    t_level_clear();
    t_set();
    t_status_ro();
    t_mask();
    t_bank_iso();
    finish_run();
  end
endmodule